// File: doc/BRIEF.md
# Dual-Mode Count Prescaler and Input Filter

This block drives the increment input of a low-power counter. It produces a strobe one system clock wide. In time mode it counts the rising edges of one of four clock sources and raises the strobe once for every 2^(N+1) of those edges, where N is a 4-bit prescale code. In pulse mode it watches an external pin through a two-flop synchronizer. It accepts a new pin level only after that level has held for 2^N rising edges of the selected source. It raises the strobe for every accepted low-to-high change. A bypass setting skips the divider or the filter, so the strobe follows each rising edge of the source in time mode, or each rising edge of the synchronized pin in pulse mode.

The mode, code, bypass and source select are loaded together on a write strobe, and only while the block is disabled. A finite-state machine picks the working path from the loaded settings. Its states are `ST_OFF` (disabled, internal counts held clear), `ST_DIVIDE` (time-mode divider), `ST_FILTER` (pulse-mode filter), `ST_PASS` (bypass in either mode) and `ST_BLOCKED` (pulse mode with the filter active and code 0, which has no filter length). The transitions are as follows. The machine goes to `ST_OFF` in any cycle where enable is low. From `ST_OFF` it moves to the path state that the settings select when enable goes high. It stays in that state while enable stays high, because the settings cannot change then.

Top module: `lpt_prefilter`

## Requirements
- R1: In time mode with bypass clear, code N (0..15) yields one strobe per 2^(N+1) rising edges of the selected source, at a steady period.
- R2: The 2-bit select value k routes source bit k of `src_i` to the divider or filter.
- R3: In pulse mode with bypass clear and N in 1..15, a pin level is accepted after 2^N rising edges of the selected source seen while the synchronized pin differs from the accepted level. An accepted low-to-high change gives exactly one strobe, and an accepted high-to-low change gives none.
- R4: When the synchronized pin returns to the accepted level before acceptance, the filter count restarts from zero. A train of pulses, each shorter than the filter length, therefore yields no strobe however long it runs.
- R5: In pulse mode with bypass clear and code 0, the block never strobes.
- R6: With bypass set, the strobe follows each rising edge of the selected source in time mode, and each rising edge of the synchronized pin in pulse mode.
- R7: Settings (`cfg_pulse_i`, `cfg_code_i`, `cfg_bypass_i`, `cfg_sel_i`) load when `cfg_we_i` is high and `en_i` is low. A write made while `en_i` is high has no effect.
- R8: While `en_i` is low, no strobe is issued. Disabling clears the divider and filter counts, and the accepted level follows the pin, so after re-enabling the first divided strobe comes one full period later.
- R9: `step_o` is low after reset and is never high for two cycles in a row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Block enable |
| cfg_we_i | input | 1 | Settings load strobe (honoured only while disabled) |
| cfg_pulse_i | input | 1 | Mode to load: 1 pulse mode, 0 time mode |
| cfg_code_i | input | 4 | Prescale / filter code to load |
| cfg_bypass_i | input | 1 | Bypass setting to load |
| cfg_sel_i | input | 2 | Source select to load |
| src_i | input | 4 | Four prescaler/filter clock sources, sampled by `clk` |
| pin_i | input | 1 | External pulse input, asynchronous |
| step_o | output | 1 | One-cycle increment strobe for the counter |

## Verification
The hardest case to reach from the ports is the filter restart. The bench must show that a count built up by several short excursions of the pin is thrown away, and not summed toward acceptance. A long run of closely spaced short pulses does this. Their combined high time is well above the filter length, but each pulse stays under it, so a filter that only counted edges and never cleared would accept one of them. The bench also sweeps every source select against several codes. It computes each strobe period from the source's own period. A wrong power-of-two offset or a wrong mux index would show up as a period that is off by a factor.

// File: rtl/lpt_pkg.sv
package lpt_pkg;
    typedef enum logic [2:0] {
        ST_OFF,
        ST_DIVIDE,
        ST_FILTER,
        ST_PASS,
        ST_BLOCKED
    } lpt_state_e;
endpackage

// File: rtl/lpt_sync2.sv
module lpt_sync2 (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic level_o,
    output logic rise_o
);
    logic meta_q, lvl_q, prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= 1'b0;
            lvl_q  <= 1'b0;
            prev_q <= 1'b0;
        end else begin
            meta_q <= async_i;
            lvl_q  <= meta_q;
            prev_q <= lvl_q;
        end
    end

    assign level_o = lvl_q;
    assign rise_o  = lvl_q & ~prev_q;
endmodule

// File: rtl/lpt_src_edge.sv
module lpt_src_edge #(
    parameter int NSRC  = 4,
    parameter int SEL_W = $clog2(NSRC)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NSRC-1:0]  src_i,
    input  logic [SEL_W-1:0] sel_i,
    output logic             rise_o
);
    logic cur, prev_q;

    assign cur = src_i[sel_i];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= cur;
    end

    assign rise_o = cur & ~prev_q;
endmodule

// File: rtl/lpt_div.sv
module lpt_div #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic             tick_i,
    input  logic [CNT_W-1:0] lim_i,
    output logic             tc_o,
    output logic [CNT_W-1:0] cnt_o
);
    logic [CNT_W-1:0] cnt_q;

    assign tc_o = tick_i && (cnt_q == lim_i);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      cnt_q <= '0;
        else if (clr_i)  cnt_q <= '0;
        else if (tc_o)   cnt_q <= '0;
        else if (tick_i) cnt_q <= cnt_q + 1'b1;
    end

    assign cnt_o = cnt_q;
endmodule

// File: rtl/lpt_glitch.sv
module lpt_glitch #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic             tick_i,
    input  logic             raw_i,
    input  logic [CNT_W-1:0] lim_i,
    output logic             acc_rise_o
);
    logic [CNT_W-1:0] cnt_q;
    logic             lvl_q;
    logic             accept;

    assign accept     = !clr_i && (raw_i != lvl_q) && tick_i && (cnt_q == lim_i);
    assign acc_rise_o = accept && raw_i;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            lvl_q <= 1'b0;
        end else if (clr_i) begin
            cnt_q <= '0;
            lvl_q <= raw_i;
        end else if (raw_i == lvl_q) begin
            cnt_q <= '0;
        end else if (accept) begin
            cnt_q <= '0;
            lvl_q <= raw_i;
        end else if (tick_i) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/lpt_prefilter.sv
module lpt_prefilter #(
    parameter int CODE_W = 4,
    parameter int NSRC   = 4,
    parameter int SEL_W  = $clog2(NSRC)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_i,
    input  logic              cfg_we_i,
    input  logic              cfg_pulse_i,
    input  logic [CODE_W-1:0] cfg_code_i,
    input  logic              cfg_bypass_i,
    input  logic [SEL_W-1:0]  cfg_sel_i,
    input  logic [NSRC-1:0]   src_i,
    input  logic              pin_i,
    output logic              step_o
);
    import lpt_pkg::*;

    localparam int CNT_W    = 2 ** CODE_W;
    localparam int MAX_CODE = CNT_W - 1;

    logic              pulse_q, byp_q;
    logic [CODE_W-1:0] code_q;
    logic [SEL_W-1:0]  sel_q;
    lpt_state_e        state_q, state_d;
    logic [CNT_W-1:0]  div_lim, filt_lim, div_cnt;
    logic              src_rise, pin_lvl, pin_rise, div_tc, filt_rise;
    logic              clr, step_d;

    // settings load only while disabled
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pulse_q <= 1'b0;
            byp_q   <= 1'b0;
            code_q  <= '0;
            sel_q   <= '0;
        end else if (cfg_we_i && !en_i) begin
            pulse_q <= cfg_pulse_i;
            byp_q   <= cfg_bypass_i;
            code_q  <= cfg_code_i;
            sel_q   <= cfg_sel_i;
        end
    end

    // terminal counts: 2^(N+1)-1 for the divider, 2^N-1 for the filter
    assign div_lim  = {CNT_W{1'b1}} >> (CODE_W'(MAX_CODE) - code_q);
    assign filt_lim = div_lim >> 1;
    assign clr      = (state_q == ST_OFF);

    lpt_sync2 i_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (pin_i),
        .level_o (pin_lvl),
        .rise_o  (pin_rise)
    );

    lpt_src_edge #(.NSRC(NSRC), .SEL_W(SEL_W)) i_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .src_i  (src_i),
        .sel_i  (sel_q),
        .rise_o (src_rise)
    );

    lpt_div #(.CNT_W(CNT_W)) i_div (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr_i  (clr),
        .tick_i (src_rise),
        .lim_i  (div_lim),
        .tc_o   (div_tc),
        .cnt_o  (div_cnt)
    );

    lpt_glitch #(.CNT_W(CNT_W)) i_filt (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr_i      (clr),
        .tick_i     (src_rise),
        .raw_i      (pin_lvl),
        .lim_i      (filt_lim),
        .acc_rise_o (filt_rise)
    );

    // next-state selection
    always_comb begin
        if (!en_i)             state_d = ST_OFF;
        else if (byp_q)        state_d = ST_PASS;
        else if (!pulse_q)     state_d = ST_DIVIDE;
        else if (code_q == '0) state_d = ST_BLOCKED;
        else                   state_d = ST_FILTER;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_OFF;
        else        state_q <= state_d;
    end

    // outputs
    always_comb begin
        unique case (state_q)
            ST_OFF:     step_d = 1'b0;
            ST_DIVIDE:  step_d = div_tc;
            ST_FILTER:  step_d = filt_rise;
            ST_PASS:    step_d = pulse_q ? pin_rise : src_rise;
            ST_BLOCKED: step_d = 1'b0;
            default:    step_d = 1'b0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) step_o <= 1'b0;
        else        step_o <= en_i && step_d;
    end
endmodule

// File: rtl/lpt_prefilter_chk.sv
module lpt_prefilter_chk #(
    parameter int CODE_W = 4,
    parameter int SEL_W  = 2,
    parameter int CNT_W  = 16
) (
    input logic               clk,
    input logic               rst_n,
    input logic               en_i,
    input logic               step_o,
    input lpt_pkg::lpt_state_e state_q,
    input logic               pulse_q,
    input logic               byp_q,
    input logic [CODE_W-1:0]  code_q,
    input logic [SEL_W-1:0]   sel_q,
    input logic [CNT_W-1:0]   div_cnt,
    input logic [CNT_W-1:0]   div_lim
);
    AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        step_o |=> !step_o); // R9

    AST_OFF_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> !step_o); // R8

    AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        en_i |=> $stable({pulse_q, byp_q, code_q, sel_q})); // R7

    AST_BLOCKED_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == lpt_pkg::ST_BLOCKED) |=> !step_o); // R5

    AST_DIV_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == lpt_pkg::ST_DIVIDE) |-> (div_cnt <= div_lim)); // R1
endmodule

bind lpt_prefilter lpt_prefilter_chk #(
    .CODE_W (CODE_W),
    .SEL_W  (SEL_W),
    .CNT_W  (CNT_W)
) i_lpt_prefilter_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .en_i    (en_i),
    .step_o  (step_o),
    .state_q (state_q),
    .pulse_q (pulse_q),
    .byp_q   (byp_q),
    .code_q  (code_q),
    .sel_q   (sel_q),
    .div_cnt (div_cnt),
    .div_lim (div_lim)
);

// File: tb/test_lpt_prefilter.sv
module test_lpt_prefilter;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       en_i = 1'b0;
    logic       cfg_we_i = 1'b0;
    logic       cfg_pulse_i = 1'b0;
    logic [3:0] cfg_code_i = '0;
    logic       cfg_bypass_i = 1'b0;
    logic [1:0] cfg_sel_i = '0;
    logic [3:0] src_i = '0;
    logic       pin_i = 1'b0;
    logic       step_o;

    int cyc = 0;
    int nstrobe = 0;
    int t_last = 0;
    int t_prev = 0;
    int nchk = 0;
    int nfail = 0;
    bit done = 0;

    lpt_prefilter i_lpt_prefilter (
        .clk          (clk),
        .rst_n        (rst_n),
        .en_i         (en_i),
        .cfg_we_i     (cfg_we_i),
        .cfg_pulse_i  (cfg_pulse_i),
        .cfg_code_i   (cfg_code_i),
        .cfg_bypass_i (cfg_bypass_i),
        .cfg_sel_i    (cfg_sel_i),
        .src_i        (src_i),
        .pin_i        (pin_i),
        .step_o       (step_o)
    );

    always #5 clk = ~clk;

    // sources: bit k toggles every k+1 cycles, so it rises every 2(k+1) cycles;
    // strobe monitor shares the same process to keep timestamps consistent
    initial begin
        forever begin
            @(negedge clk);
            cyc++;
            for (int k = 0; k < 4; k++) src_i[k] = ((cyc / (k + 1)) % 2) == 1;
            if (step_o) begin
                nstrobe++;
                t_prev = t_last;
                t_last = cyc;
            end
        end
    end

    task automatic check(input string req, input int act, input int exp_v);
        nchk++;
        if (act != exp_v) begin
            nfail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp_v);
        end
    endtask

    task automatic check_range(input string req, input int act, input int lo, input int hi);
        nchk++;
        if (act < lo || act > hi) begin
            nfail++;
            $display("FAIL %s: actual %0d expected %0d..%0d", req, act, lo, hi);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic load(input bit pulse, input int code, input bit byp, input int sel, input bit en_during);
        @(negedge clk);
        en_i = en_during;
        cfg_we_i = 1'b1;
        cfg_pulse_i = pulse;
        cfg_code_i = 4'(code);
        cfg_bypass_i = byp;
        cfg_sel_i = 2'(sel);
        @(negedge clk);
        cfg_we_i = 1'b0;
    endtask

    task automatic wait_strobes(input int n, input int limit);
        int target;
        target = nstrobe + n;
        for (int i = 0; i < limit && nstrobe < target; i++) @(negedge clk);
    endtask

    // period between two consecutive strobes, after enabling
    task automatic measure(output int per);
        en_i = 1'b1;
        wait_strobes(1, 5000);
        wait_strobes(1, 5000);
        per = t_last - t_prev;
        @(negedge clk);
        en_i = 1'b0;
        idle(4);
    endtask

    task automatic pulse_pin(input int width, input int gap);
        @(negedge clk);
        pin_i = 1'b1;
        idle(width);
        pin_i = 1'b0;
        idle(gap);
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            nfail++;
            $display("FAIL watchdog: actual 1 expected 0");
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
        end
    end

    initial begin
        int per, n0, t0, exp_p;
        idle(3);
        check("R9 reset strobe low", int'(step_o), 0);
        rst_n = 1'b1;
        idle(3);
        check("R9 strobe low after reset", int'(step_o), 0);

        // R1 / R2 sweep: every source against codes 0..5
        for (int sel = 0; sel < 4; sel++) begin
            for (int code = 0; code < 6; code++) begin
                load(1'b0, code, 1'b0, sel, 1'b0);
                measure(per);
                exp_p = (2 ** (code + 1)) * 2 * (sel + 1);
                check($sformatf("R1 R2 divide sel=%0d code=%0d", sel, code), per, exp_p);
            end
            // R6 time-mode bypass
            load(1'b0, 7, 1'b1, sel, 1'b0);
            measure(per);
            check($sformatf("R6 time bypass sel=%0d", sel), per, 2 * (sel + 1));
        end

        // R7: write while enabled is ignored
        load(1'b0, 1, 1'b0, 0, 1'b0);
        en_i = 1'b1;
        idle(20);
        load(1'b0, 4, 1'b0, 3, 1'b1);
        measure(per);
        check("R7 write while enabled ignored", per, 8);
        load(1'b0, 2, 1'b0, 0, 1'b0);
        measure(per);
        check("R7 write while disabled taken", per, 16);

        // R8: disabled gives no strobe
        load(1'b0, 0, 1'b1, 0, 1'b0);
        n0 = nstrobe;
        idle(100);
        check("R8 no strobe while disabled", nstrobe - n0, 0);

        // R8: disable clears the divider count
        load(1'b0, 4, 1'b0, 0, 1'b0);
        en_i = 1'b1;
        idle(40);
        en_i = 1'b0;
        idle(3);
        n0 = nstrobe;
        en_i = 1'b1;
        t0 = cyc;
        wait_strobes(1, 500);
        check_range("R8 full period after re-enable", t_last - t0, 60, 68);
        en_i = 1'b0;
        idle(4);

        // R3 / R4 filter on source 0 (edge every 2 cycles)
        for (int code = 1; code < 6; code++) begin
            load(1'b1, code, 1'b0, 0, 1'b0);
            en_i = 1'b1;
            idle(10);
            n0 = nstrobe;
            pulse_pin(2 ** code - 1, 2 ** (code + 1) + 12);
            check($sformatf("R3 short pulse rejected code=%0d", code), nstrobe - n0, 0);
            n0 = nstrobe;
            pulse_pin(2 ** (code + 1) + 8, 2 ** (code + 1) + 12);
            check($sformatf("R3 long pulse one strobe code=%0d", code), nstrobe - n0, 1);
            en_i = 1'b0;
            idle(4);
        end

        // R4: train of short pulses, total high time far above filter length
        load(1'b1, 3, 1'b0, 0, 1'b0);
        en_i = 1'b1;
        idle(10);
        n0 = nstrobe;
        for (int i = 0; i < 12; i++) pulse_pin(5, 2);
        idle(40);
        check("R4 glitch train rejected", nstrobe - n0, 0);
        en_i = 1'b0;
        idle(4);

        // R5: code 0 in filter mode never strobes
        load(1'b1, 0, 1'b0, 0, 1'b0);
        en_i = 1'b1;
        idle(10);
        n0 = nstrobe;
        pulse_pin(60, 40);
        pulse_pin(60, 40);
        check("R5 code 0 filter silent", nstrobe - n0, 0);
        en_i = 1'b0;
        idle(4);

        // R6: pulse-mode bypass counts each pin rise
        load(1'b1, 5, 1'b1, 2, 1'b0);
        en_i = 1'b1;
        idle(10);
        n0 = nstrobe;
        for (int i = 0; i < 5; i++) pulse_pin(3, 3);
        idle(10);
        check("R6 pulse bypass count", nstrobe - n0, 5);
        en_i = 1'b0;
        idle(4);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end
endmodule